// File: doc/BRIEF.md
# TDM Timeslot Channel-ID Mapper

This block turns a position on a byte-interleaved add/drop bus into one flat channel number. The bus carries several SDH tributaries side by side, one byte each in turn. Each tributary holds either E1 or T1 links, and each link is cut into timeslots. A free-running sweep walks every position of a frame. The tributary number changes fastest, then the link, then the timeslot. For each position the block gives a channel ID that a packet-based TDM engine uses directly as a buffer index.

A single mode input picks E1 or T1 numbering. The block copies that input only at a frame boundary, so no frame mixes the two numbering plans. The outputs are registered and appear together: the channel ID, a valid strobe, a one-cycle frame-start flag, the decoded tributary, link and timeslot numbers, and the numbering plan in force for the current frame. A build parameter chooses how the ID is formed. One choice multiplies out the formula at each position. The other keeps a running count that is cleared at each frame start.

Top module: `tdm_chan_mapper`

## Requirements
- R1: While rst_n is low, every output is 0. After rst_n is released, chan_vld stays low at the first rising edge and goes high at the second rising edge. From then on it stays high until the next reset.
- R2: Positions follow one another with the tributary index changing fastest, then the link index, then the timeslot index. Each index returns to 0 after its last value. After the last position of a frame the sweep wraps to position 0, and chan_id rises by exactly 1 from each position to the next within a frame.
- R3: With E1 numbering, link_idx runs 0 to E1_LINKS-1 (63 by default) and slot_idx runs 0 to E1_SLOTS-1 (32 by default). chan_id = ((slot_idx * E1_LINKS) + link_idx) * NUM_STM + stm_idx.
- R4: With T1 numbering, link_idx runs 0 to T1_LINKS-1 (84 by default) and slot_idx runs 0 to T1_SLOTS-1 (24 by default). chan_id = ((slot_idx * T1_LINKS) + link_idx) * NUM_STM + stm_idx.
- R5: A frame uses T1 numbering when mode_t1 was 1 at the edge where it was sampled, and E1 numbering when it was 0. The t1_mode output is 1 exactly for frames that use T1 numbering.
- R6: mode_t1 is sampled only at the first rising edge after reset release and at the rising edge that moves the sweep from the last position of a frame to position 0. Changes at any other time have no effect until the next such edge.
- R7: frame_start is high for exactly one cycle per frame, in the cycle whose outputs show position 0. In that cycle chan_id, stm_idx, link_idx and slot_idx are all 0.
- R8: The chan_id width is derived from a cap of 8192 IDs. Every valid chan_id is below the number of positions in the current frame, which is 8064 by default in both modes.
- R9: The multiply build (ID_BY_COUNT = 0) and the counting build (ID_BY_COUNT = 1) give the same outputs on every cycle for the same reset and mode_t1 stimulus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, one position per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_t1 | input | 1 | Numbering select: 1 for T1, 0 for E1; sampled at frame boundaries |
| chan_id | output | ID_W (13) | Flat channel ID of the current position |
| chan_vld | output | 1 | Outputs hold a valid position |
| frame_start | output | 1 | Current position is the first of a frame |
| stm_idx | output | STM_W (2) | Tributary index of the current position |
| link_idx | output | LINK_W (7) | Link index of the current position |
| slot_idx | output | SLOT_W (5) | Timeslot index of the current position |
| t1_mode | output | 1 | Numbering plan in force for the current frame |

## Verification
The bench builds two copies side by side with four tributaries and small frames: 5 links by 4 timeslots for E1 and 7 links by 3 timeslots for T1. Frames therefore last 80 and 84 cycles. This lets the bench walk many complete frames and cross many wraps of every index, in both plans. One copy multiplies and the other counts, so any disagreement between the two ID paths shows at once. The short frames also make the boundary cases easy to hit at exact cycles. The mode input is flipped mid-frame, exactly at the last sampling edge, and one cycle too late for it. A reset is also applied mid-frame.

// File: rtl/tdm_map_pkg.sv
// Package: shared types for the TDM channel-ID mapper.
// Assumes: numbering plans are only E1 and T1.
package tdm_map_pkg;

    typedef enum logic {
        NUM_E1 = 1'b0,
        NUM_T1 = 1'b1
    } num_mode_e;

    // Number of sweep positions in one frame for a given plan size.
    function automatic int frame_positions(input int links, input int slots, input int nstm);
        return links * slots * nstm;
    endfunction

endpackage

// File: rtl/tdm_pos_sweep.sv
// Module: tdm_pos_sweep
// Walks every bus position: tributary index innermost, then link, then
// timeslot. It latches the numbering plan at sweep start and at each frame
// wrap, so the plan is fixed for a whole frame.
// Assumes: the counter widths hold the largest link and slot counts.
module tdm_pos_sweep
    import tdm_map_pkg::*;
#(
    parameter int NUM_STM  = 4,
    parameter int E1_LINKS = 63,
    parameter int E1_SLOTS = 32,
    parameter int T1_LINKS = 84,
    parameter int T1_SLOTS = 24,
    parameter int STM_W    = 2,
    parameter int LINK_W   = 7,
    parameter int SLOT_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_t1_i,
    output logic              pos_vld_o,
    output logic              pos_first_o,
    output num_mode_e         mode_o,
    output logic [STM_W-1:0]  stm_o,
    output logic [LINK_W-1:0] link_o,
    output logic [SLOT_W-1:0] slot_o
);

    logic              running_q;
    num_mode_e         mode_q;
    logic [STM_W-1:0]  stm_q;
    logic [LINK_W-1:0] link_q;
    logic [SLOT_W-1:0] slot_q;

    logic              stm_last;
    logic              link_last;
    logic              slot_last;
    logic [LINK_W-1:0] link_top;
    logic [SLOT_W-1:0] slot_top;

    // Pick the last link and slot values for the plan in force.
    always_comb begin
        if (mode_q == NUM_T1) begin
            link_top = LINK_W'(T1_LINKS - 1);
            slot_top = SLOT_W'(T1_SLOTS - 1);
        end else begin
            link_top = LINK_W'(E1_LINKS - 1);
            slot_top = SLOT_W'(E1_SLOTS - 1);
        end
    end

    // Detect the last value of each nested index.
    always_comb begin
        stm_last  = (stm_q == STM_W'(NUM_STM - 1));
        link_last = (link_q == link_top);
        slot_last = (slot_q == slot_top);
    end

    // Advance the nested counters and latch the plan at frame boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running_q <= 1'b0;
            mode_q    <= NUM_E1;
            stm_q     <= '0;
            link_q    <= '0;
            slot_q    <= '0;
        end else if (!running_q) begin
            running_q <= 1'b1;
            mode_q    <= mode_t1_i ? NUM_T1 : NUM_E1;
        end else if (!stm_last) begin
            stm_q <= stm_q + STM_W'(1);
        end else begin
            stm_q <= '0;
            if (!link_last) begin
                link_q <= link_q + LINK_W'(1);
            end else begin
                link_q <= '0;
                if (!slot_last) begin
                    slot_q <= slot_q + SLOT_W'(1);
                end else begin
                    slot_q <= '0;
                    mode_q <= mode_t1_i ? NUM_T1 : NUM_E1;
                end
            end
        end
    end

    // Present the position and its first-of-frame marker.
    always_comb begin
        pos_vld_o   = running_q;
        pos_first_o = running_q && (stm_q == '0) && (link_q == '0) && (slot_q == '0);
        mode_o      = mode_q;
        stm_o       = stm_q;
        link_o      = link_q;
        slot_o      = slot_q;
    end

endmodule

// File: rtl/tdm_id_mult.sv
// Module: tdm_id_mult
// Forms the channel ID for a position by multiplying out the nested formula.
// Assumes: ID_W is wide enough for the largest frame; purely combinational.
module tdm_id_mult
    import tdm_map_pkg::*;
#(
    parameter int NUM_STM  = 4,
    parameter int E1_LINKS = 63,
    parameter int T1_LINKS = 84,
    parameter int STM_W    = 2,
    parameter int LINK_W   = 7,
    parameter int SLOT_W   = 5,
    parameter int ID_W     = 13
) (
    input  num_mode_e         mode_i,
    input  logic [STM_W-1:0]  stm_i,
    input  logic [LINK_W-1:0] link_i,
    input  logic [SLOT_W-1:0] slot_i,
    output logic [ID_W-1:0]   id_o
);

    logic [ID_W-1:0] links_w;
    logic [ID_W-1:0] row_w;

    // Select the links-per-timeslot multiplier for the plan.
    always_comb begin
        links_w = (mode_i == NUM_T1) ? ID_W'(T1_LINKS) : ID_W'(E1_LINKS);
    end

    // Combine timeslot and link, then interleave the tributaries.
    always_comb begin
        row_w = (ID_W'(slot_i) * links_w) + ID_W'(link_i);
        id_o  = (row_w * ID_W'(NUM_STM)) + ID_W'(stm_i);
    end

endmodule

// File: rtl/tdm_id_count.sv
// Module: tdm_id_count
// Forms the channel ID by counting: 0 at each frame start, one more than
// the last ID at every other valid position.
// Assumes: the sweep visits positions in ID order with no gaps.
module tdm_id_count #(
    parameter int ID_W = 13
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pos_vld_i,
    input  logic            pos_first_i,
    output logic [ID_W-1:0] id_o
);

    logic [ID_W-1:0] last_q;

    // Next ID from the frame marker and the last issued ID.
    always_comb begin
        id_o = pos_first_i ? '0 : (last_q + ID_W'(1));
    end

    // Remember the ID issued at each valid position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= '0;
        end else if (pos_vld_i) begin
            last_q <= id_o;
        end
    end

endmodule

// File: rtl/tdm_chan_mapper.sv
// Module: tdm_chan_mapper (top)
// Sweeps the interleaved add/drop bus positions and gives, one register
// after the sweep counters, the flat channel ID with its decoded fields.
// Assumes: one position per clock; mode_t1 may change at any time.
module tdm_chan_mapper
    import tdm_map_pkg::*;
#(
    parameter int NUM_STM     = 4,
    parameter int E1_LINKS    = 63,
    parameter int E1_SLOTS    = 32,
    parameter int T1_LINKS    = 84,
    parameter int T1_SLOTS    = 24,
    parameter int MAX_IDS     = 8192,
    parameter bit ID_BY_COUNT = 1'b0,
    localparam int STM_W  = (NUM_STM > 1) ? $clog2(NUM_STM) : 1,
    localparam int MAX_LK = (E1_LINKS > T1_LINKS) ? E1_LINKS : T1_LINKS,
    localparam int MAX_SL = (E1_SLOTS > T1_SLOTS) ? E1_SLOTS : T1_SLOTS,
    localparam int LINK_W = (MAX_LK > 1) ? $clog2(MAX_LK) : 1,
    localparam int SLOT_W = (MAX_SL > 1) ? $clog2(MAX_SL) : 1,
    localparam int ID_W   = $clog2(MAX_IDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_t1,
    output logic [ID_W-1:0]   chan_id,
    output logic              chan_vld,
    output logic              frame_start,
    output logic [STM_W-1:0]  stm_idx,
    output logic [LINK_W-1:0] link_idx,
    output logic [SLOT_W-1:0] slot_idx,
    output logic              t1_mode
);

    logic              pos_vld;
    logic              pos_first;
    num_mode_e         pos_mode;
    logic [STM_W-1:0]  pos_stm;
    logic [LINK_W-1:0] pos_link;
    logic [SLOT_W-1:0] pos_slot;
    logic [ID_W-1:0]   pos_id;

    tdm_pos_sweep #(
        .NUM_STM  (NUM_STM),
        .E1_LINKS (E1_LINKS),
        .E1_SLOTS (E1_SLOTS),
        .T1_LINKS (T1_LINKS),
        .T1_SLOTS (T1_SLOTS),
        .STM_W    (STM_W),
        .LINK_W   (LINK_W),
        .SLOT_W   (SLOT_W)
    ) u_sweep (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_t1_i   (mode_t1),
        .pos_vld_o   (pos_vld),
        .pos_first_o (pos_first),
        .mode_o      (pos_mode),
        .stm_o       (pos_stm),
        .link_o      (pos_link),
        .slot_o      (pos_slot)
    );

    generate
        if (ID_BY_COUNT) begin : g_count
            tdm_id_count #(
                .ID_W (ID_W)
            ) u_id (
                .clk         (clk),
                .rst_n       (rst_n),
                .pos_vld_i   (pos_vld),
                .pos_first_i (pos_first),
                .id_o        (pos_id)
            );
        end else begin : g_mult
            tdm_id_mult #(
                .NUM_STM  (NUM_STM),
                .E1_LINKS (E1_LINKS),
                .T1_LINKS (T1_LINKS),
                .STM_W    (STM_W),
                .LINK_W   (LINK_W),
                .SLOT_W   (SLOT_W),
                .ID_W     (ID_W)
            ) u_id (
                .mode_i (pos_mode),
                .stm_i  (pos_stm),
                .link_i (pos_link),
                .slot_i (pos_slot),
                .id_o   (pos_id)
            );
        end
    endgenerate

    // Register the ID, the strobes and the decoded fields together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_id     <= '0;
            chan_vld    <= 1'b0;
            frame_start <= 1'b0;
            stm_idx     <= '0;
            link_idx    <= '0;
            slot_idx    <= '0;
            t1_mode     <= 1'b0;
        end else begin
            chan_vld    <= pos_vld;
            frame_start <= pos_first;
            chan_id     <= pos_vld ? pos_id : '0;
            stm_idx     <= pos_vld ? pos_stm : '0;
            link_idx    <= pos_vld ? pos_link : '0;
            slot_idx    <= pos_vld ? pos_slot : '0;
            t1_mode     <= pos_vld && (pos_mode == NUM_T1);
        end
    end

endmodule

// File: rtl/tdm_chan_mapper_chk.sv
// Module: tdm_chan_mapper_chk
// Checks the mapper's port behaviour over time. Bound to every instance
// of tdm_chan_mapper.
module tdm_chan_mapper_chk #(
    parameter int NUM_STM  = 4,
    parameter int E1_LINKS = 63,
    parameter int E1_SLOTS = 32,
    parameter int T1_LINKS = 84,
    parameter int T1_SLOTS = 24,
    parameter int ID_W     = 13,
    parameter int STM_W    = 2,
    parameter int LINK_W   = 7,
    parameter int SLOT_W   = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ID_W-1:0]   chan_id,
    input logic              chan_vld,
    input logic              frame_start,
    input logic [STM_W-1:0]  stm_idx,
    input logic [LINK_W-1:0] link_idx,
    input logic [SLOT_W-1:0] slot_idx,
    input logic              t1_mode
);

    localparam int E1_POS = E1_LINKS * E1_SLOTS * NUM_STM;
    localparam int T1_POS = T1_LINKS * T1_SLOTS * NUM_STM;

    // R7
    frame_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (chan_vld && chan_id == '0 && stm_idx == '0
                         && link_idx == '0 && slot_idx == '0));

    // R2
    id_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_vld && !frame_start) |-> (chan_id == $past(chan_id) + ID_W'(1)));

    // R2
    stm_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_vld && !frame_start) |->
            (int'(stm_idx) == ((int'($past(stm_idx)) == NUM_STM - 1) ? 0
                               : int'($past(stm_idx)) + 1)));

    // R6
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_vld && !frame_start) |-> $stable(t1_mode));

    // R3
    field_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chan_vld |-> (int'(link_idx) < (t1_mode ? T1_LINKS : E1_LINKS)
                      && int'(slot_idx) < (t1_mode ? T1_SLOTS : E1_SLOTS)));

    // R8
    id_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chan_vld |-> (int'(chan_id) < (t1_mode ? T1_POS : E1_POS)));

    // R1
    vld_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(chan_vld) |-> chan_vld);

endmodule

bind tdm_chan_mapper tdm_chan_mapper_chk #(
    .NUM_STM  (NUM_STM),
    .E1_LINKS (E1_LINKS),
    .E1_SLOTS (E1_SLOTS),
    .T1_LINKS (T1_LINKS),
    .T1_SLOTS (T1_SLOTS),
    .ID_W     (ID_W),
    .STM_W    (STM_W),
    .LINK_W   (LINK_W),
    .SLOT_W   (SLOT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .chan_id     (chan_id),
    .chan_vld    (chan_vld),
    .frame_start (frame_start),
    .stm_idx     (stm_idx),
    .link_idx    (link_idx),
    .slot_idx    (slot_idx),
    .t1_mode     (t1_mode)
);

// File: tb/sim_tdm_chan_mapper.sv
// Bench: directed scenarios on two small builds (multiply and count).
module sim_tdm_chan_mapper;

    localparam int NSTM = 4;
    localparam int E1L  = 5;
    localparam int E1S  = 4;
    localparam int T1L  = 7;
    localparam int T1S  = 3;
    localparam int E1_LEN = NSTM * E1L * E1S;
    localparam int T1_LEN = NSTM * T1L * T1S;

    logic        clk;
    logic        rst_n;
    logic        mode_t1;
    logic [12:0] id0, id1;
    logic        vld0, vld1, fs0, fs1, t10, t11;
    logic [1:0]  stm0, stm1;
    logic [2:0]  link0, link1;
    logic [1:0]  slot0, slot1;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    tdm_chan_mapper #(
        .NUM_STM(NSTM), .E1_LINKS(E1L), .E1_SLOTS(E1S),
        .T1_LINKS(T1L), .T1_SLOTS(T1S), .ID_BY_COUNT(1'b0)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .mode_t1(mode_t1),
        .chan_id(id0), .chan_vld(vld0), .frame_start(fs0),
        .stm_idx(stm0), .link_idx(link0), .slot_idx(slot0), .t1_mode(t10)
    );

    tdm_chan_mapper #(
        .NUM_STM(NSTM), .E1_LINKS(E1L), .E1_SLOTS(E1S),
        .T1_LINKS(T1L), .T1_SLOTS(T1S), .ID_BY_COUNT(1'b1)
    ) u1 (
        .clk(clk), .rst_n(rst_n), .mode_t1(mode_t1),
        .chan_id(id1), .chan_vld(vld1), .frame_start(fs1),
        .stm_idx(stm1), .link_idx(link1), .slot_idx(slot1), .t1_mode(t11)
    );

    initial begin
        clk = 1'b0;
        forever #2 clk = ~clk;
    end

    // Record one check and print a FAIL line on mismatch.
    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // R1: hold reset, check all outputs are 0, release, check valid timing.
    task automatic do_reset(input bit m);
        @(negedge clk);
        rst_n   = 1'b0;
        mode_t1 = m;
        repeat (3) @(negedge clk);
        chk(!vld0 && !fs0 && id0 == 0 && stm0 == 0 && link0 == 0 && slot0 == 0 && !t10,
            "R1", "outputs in reset (id0)", int'(id0) + int'(vld0), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!vld0 && !vld1, "R1", "valid after first edge", int'(vld0), 0);
        @(negedge clk);
        chk(vld0 && vld1, "R1", "valid after second edge", int'(vld0), 1);
    endtask

    // R2 R3 R4 R5 R6 R7 R8 R9: walk one frame, check every position against
    // the formula; optionally flip mode_t1 after position flip_at.
    task automatic walk_frame(input bit t1, input int flip_at, input bit flip_val,
                              input string req);
        int nl  = t1 ? T1L : E1L;
        int len = t1 ? T1_LEN : E1_LEN;
        for (int idx = 0; idx < len; idx++) begin
            int m  = idx % NSTM;
            int l  = (idx / NSTM) % nl;
            int s  = idx / (NSTM * nl);
            int ex = ((s * nl) + l) * NSTM + m;
            bit ok = vld0 && (int'(id0) == ex) && (int'(stm0) == m) && (int'(link0) == l)
                     && (int'(slot0) == s) && (fs0 == (idx == 0)) && (t10 == t1)
                     && (ex < 8192);
            chk(ok, req, $sformatf("chan_id at position %0d", idx), int'(id0), ex);
            chk({id1, vld1, fs1, stm1, link1, slot1, t11} ==
                {id0, vld0, fs0, stm0, link0, slot0, t10},
                "R9", $sformatf("count build id at position %0d", idx), int'(id1), int'(id0));
            if (idx == flip_at) mode_t1 = flip_val;
            @(negedge clk);
        end
    endtask

    // E1 frames after reset with the mode held low.
    task automatic t_e1_plain();
        walk_frame(1'b0, -1, 1'b0, "R3");
        walk_frame(1'b0, -1, 1'b0, "R2");
    endtask

    // R6: mid-frame flip to T1 keeps E1 for the rest of the frame.
    task automatic t_flip_mid();
        walk_frame(1'b0, 20, 1'b1, "R6");
        walk_frame(1'b1, -1, 1'b1, "R4");
    endtask

    // R6: flip while the last position is being counted takes effect next frame.
    task automatic t_flip_last_edge();
        walk_frame(1'b1, T1_LEN - 2, 1'b0, "R6");
        walk_frame(1'b0, -1, 1'b0, "R5");
    endtask

    // R6: flip one cycle too late stays out of the next frame.
    task automatic t_flip_late();
        walk_frame(1'b0, E1_LEN - 1, 1'b1, "R6");
        walk_frame(1'b0, -1, 1'b1, "R6");
        walk_frame(1'b1, -1, 1'b1, "R5");
    endtask

    // R1: reset in the middle of a frame restarts at position 0 in T1 mode.
    task automatic t_mid_reset();
        repeat (7) @(negedge clk);
        do_reset(1'b1);
        walk_frame(1'b1, -1, 1'b1, "R7");
        walk_frame(1'b1, -1, 1'b1, "R8");
    endtask

    initial begin
        rst_n   = 1'b0;
        mode_t1 = 1'b0;
        do_reset(1'b0);
        t_e1_plain();
        t_flip_mid();
        t_flip_last_edge();
        t_flip_late();
        t_mid_reset();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog: a hung run is one failed check.
    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R2 watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule